// File: doc/BRIEF.md
# Successive-Approximation Offset Calibrator

This block searches for the digital trim word that cancels an amplifier's input offset. While it calibrates, the amplifier runs open loop and its output sits at one rail or the other. The block takes only the sign of that output as its decision bit. The trim word drives a current DAC. The DAC's output, which spans zero to twice a reference, is set against a fixed current of the opposite polarity. The mid-scale code is therefore the point of zero net correction, and offsets of either polarity can be reached.

A calibration starts with a start pulse. The search begins at the mid-scale code and resolves one bit per step, most significant bit first. Each step is taken on a slow step strobe, because the open-loop output needs a long time to settle when the residual error is small. The sign input is asynchronous to the clock and passes through a two-flop synchronizer. During a search the trial word is presented on its own output so that it can drive the DAC of the amplifier under calibration. The final word is held in a separate register, which changes only when a search completes. At that point a one-cycle done pulse is raised.

Top module: `offset_sar_cal`

## Requirements
- R1: While reset is applied and after it is released, the final word and the trial word both read mid-scale 0x80, busy is 0 and done is 0.
- R2: A start pulse while idle makes busy 1 and sets the trial word to 0x80 on the next clock edge.
- R3: On each step strobe during a search, the bit under test is kept when the synchronized sign is 1 (amplifier output high, compensation too small) and cleared when it is 0. The next lower bit is then set as the new trial. Exactly 8 steps resolve bits 7 down to 0.
- R4: The sign reaches the search through two flip-flops. A change at the sign input is used by a step only after it has been captured on two clock edges before the edge that samples the step strobe. A change made one cycle before that edge is not yet seen.
- R5: Done is high for exactly one cycle, in the cycle after the edge that takes the eighth step. In that cycle busy is already 0.
- R6: The final word changes only in the cycle where done is high, and then it takes the resolved code. Throughout a search it keeps the previous result.
- R7: A start pulse during a search is ignored, including one in the same cycle as the eighth step: the trial word, the bit order and the result are unaffected.
- R8: A step strobe while idle changes neither the trial word nor the final word, and it raises no done pulse.
- R9: If the sign follows "trial word ≤ T" for a threshold T, the search ends with the final word equal to T, for every T from 0x00 to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle request to begin a calibration |
| step_en_i | input | 1 | Slow step strobe, one cycle wide, that triggers one bit decision |
| sign_async_i | input | 1 | Sign of the saturated amplifier output, asynchronous (1 = high rail) |
| trial_code_o | output | 8 | Trial word for the DAC during a search |
| final_code_o | output | 8 | Held calibration result |
| busy_o | output | 1 | A search is in progress |
| done_o | output | 1 | One-cycle pulse when a result is stored |

## Verification
Two functions can fall in the same clock cycle. One is the last bit decision, which completes the search. The other is a new start request. The bench drives a start pulse in the same cycle as the eighth step strobe and requires that it be dropped: done must pulse, the stored result must equal the threshold, and busy must fall. It then drives a start in the very cycle where done is high and requires that a fresh search begin at mid-scale. The bench also checks the boundary of the synchronizer delay. It changes the sign one cycle before a step and requires that the step still uses the old sign.

// File: rtl/sarcal_pkg.sv
package sarcal_pkg;
  typedef enum logic {
    SAR_IDLE = 1'b0,
    SAR_RUN  = 1'b1
  } sar_mode_e;
endpackage

// File: rtl/sign_sync.sv
module sign_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_n;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sar_core.sv
module sar_core
  import sarcal_pkg::*;
#(
  parameter int CODE_W = 8,
  localparam int PTR_W = (CODE_W > 1) ? $clog2(CODE_W) : 1
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              step_en_i,
  input  logic              sign_i,
  output logic [CODE_W-1:0] trial_o,
  output logic              busy_o,
  output logic              fin_o,
  output logic [CODE_W-1:0] fin_code_o
);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [PTR_W-1:0]  TOP = PTR_W'(CODE_W-1);

  sar_mode_e         mode_q, mode_n;
  logic [CODE_W-1:0] trial_q, trial_n;
  logic [PTR_W-1:0]  ptr_q, ptr_n, ptr_dec;
  logic              fin_c;

  assign ptr_dec = ptr_q - 1'b1;

  always_comb begin
    mode_n  = mode_q;
    trial_n = trial_q;
    ptr_n   = ptr_q;
    fin_c   = 1'b0;
    case (mode_q)
      SAR_IDLE: begin
        if (start_i) begin
          mode_n  = SAR_RUN;
          trial_n = MID;
          ptr_n   = TOP;
        end
      end
      SAR_RUN: begin
        if (step_en_i) begin
          trial_n[ptr_q] = sign_i;
          if (ptr_q == '0) begin
            mode_n = SAR_IDLE;
            fin_c  = 1'b1;
          end else begin
            trial_n[ptr_dec] = 1'b1;
            ptr_n            = ptr_dec;
          end
        end
      end
      default: mode_n = SAR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= SAR_IDLE;
      trial_q <= MID;
      ptr_q   <= TOP;
    end else begin
      mode_q  <= mode_n;
      trial_q <= trial_n;
      ptr_q   <= ptr_n;
    end
  end

  assign trial_o    = trial_q;
  assign busy_o     = (mode_q == SAR_RUN);
  assign fin_o      = fin_c;
  assign fin_code_o = trial_n;

  // R2: an idle start loads mid-scale and enters the search
  p_start_loads_mid_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_q == SAR_IDLE && start_i) |=> (mode_q == SAR_RUN && trial_q == MID));
  // R3: a kept bit never lowers the trial word
  p_keep_raises_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_q == SAR_RUN && step_en_i && sign_i) |=> (trial_q >= $past(trial_q)));
  // R3: a cleared bit always lowers the trial word
  p_clear_lowers_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_q == SAR_RUN && step_en_i && !sign_i) |=> (trial_q < $past(trial_q)));
  // R7: without a step the search holds, whatever start does
  p_run_holds_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_q == SAR_RUN && !step_en_i) |=> ($stable(trial_q) && mode_q == SAR_RUN));
  // R8: idle trial word is untouched by step strobes
  p_idle_step_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_q == SAR_IDLE && !start_i) |=> $stable(trial_q));
endmodule

// File: rtl/offset_sar_cal.sv
module offset_sar_cal #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              step_en_i,
  input  logic              sign_async_i,
  output logic [CODE_W-1:0] trial_code_o,
  output logic [CODE_W-1:0] final_code_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              sign_s;
  logic              fin_c;
  logic [CODE_W-1:0] fin_code_c;
  logic [CODE_W-1:0] final_q, final_n;
  logic              done_q, done_n;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sign_sync #(.STAGES(2)) u_sign_sync (
    .clk    (clk),
    .rst_ni (rst_int_n),
    .d_i    (sign_async_i),
    .q_o    (sign_s)
  );

  sar_core #(.CODE_W(CODE_W)) u_core (
    .clk        (clk),
    .rst_ni     (rst_int_n),
    .start_i    (start_i),
    .step_en_i  (step_en_i),
    .sign_i     (sign_s),
    .trial_o    (trial_code_o),
    .busy_o     (busy_o),
    .fin_o      (fin_c),
    .fin_code_o (fin_code_c)
  );

  always_comb begin
    final_n = final_q;
    done_n  = fin_c;
    if (fin_c) final_n = fin_code_c;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      final_q <= MID;
      done_q  <= 1'b0;
    end else begin
      final_q <= final_n;
      done_q  <= done_n;
    end
  end

  assign final_code_o = final_q;
  assign done_o       = done_q;

  // R5: done never lasts two cycles
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_q |=> !done_q);
  // R5: done comes with the search already closed
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_q |-> !busy_o);
  // R6: the stored result moves only alongside done
  p_final_held_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    !done_q |-> $stable(final_q));
endmodule

// File: tb/offset_sar_cal_tb_top.sv
module offset_sar_cal_tb_top;
  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic       step_en_i;
  logic       sign_async_i;
  logic [7:0] trial_code_o;
  logic [7:0] final_code_o;
  logic       busy_o;
  logic       done_o;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  offset_sar_cal #(.CODE_W(8)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .step_en_i    (step_en_i),
    .sign_async_i (sign_async_i),
    .trial_code_o (trial_code_o),
    .final_code_o (final_code_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // vector: {threshold, expected final word}
  localparam logic [15:0] VEC [8] = '{
    16'h00_00, 16'hFF_FF, 16'h80_80, 16'h7F_7F,
    16'h01_01, 16'h55_55, 16'hAA_AA, 16'hC3_C3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // called at a negedge; one-cycle step strobe, returns at the next negedge
  task automatic step_once(input logic with_start);
    step_en_i = 1'b1;
    start_i   = with_start;
    @(negedge clk);
    step_en_i = 1'b0;
    start_i   = 1'b0;
  endtask

  task automatic begin_search();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // drive the sign from "trial <= thr" and take one settled step
  task automatic model_step(input logic [7:0] thr, input logic with_start);
    sign_async_i = (trial_code_o <= thr);
    repeat (3) @(negedge clk);
    step_once(with_start);
  endtask

  initial begin
    #200000;
    $display("FAIL watchdog expired");
    bad++;
    finish_run();
  end

  initial begin
    logic [7:0] prev;
    rst_n = 1'b0; start_i = 1'b0; step_en_i = 1'b0; sign_async_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 final in reset", final_code_o, 8'h80);
    check("R1 busy in reset", busy_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 final after reset", final_code_o, 8'h80);
    check("R1 trial after reset", trial_code_o, 8'h80);
    check("R1 busy after reset", busy_o, 0);
    check("R1 done after reset", done_o, 0);

    // vector table walk
    for (int v = 0; v < 8; v++) begin
      logic [7:0] thr;
      thr = VEC[v][15:8];
      begin_search();
      check("R2 busy after start", busy_o, 1);
      check("R2 trial after start", trial_code_o, 8'h80);
      model_step(thr, 1'b0);
      check("R3 first decision", trial_code_o, {thr >= 8'h80, 7'h40});
      for (int s = 1; s < 8; s++) model_step(thr, 1'b0);
      check("R5 done pulse", done_o, 1);
      check("R5 busy low at done", busy_o, 0);
      check("R9 final word", final_code_o, VEC[v][7:0]);
      @(negedge clk);
      check("R5 done one cycle", done_o, 0);
    end

    // R6: result held through a new search
    prev = final_code_o;
    begin_search();
    for (int s = 0; s < 7; s++) begin
      model_step(8'h3C, 1'b0);
      check("R6 final held during search", final_code_o, prev);
    end
    model_step(8'h3C, 1'b0);
    check("R6 final updated at done", final_code_o, 8'h3C);

    // R7: start mid-search ignored
    begin_search();
    model_step(8'h9A, 1'b0);
    model_step(8'h9A, 1'b0);
    prev = trial_code_o;
    begin_search();
    check("R7 trial kept on busy start", trial_code_o, prev);
    check("R7 busy kept on busy start", busy_o, 1);
    for (int s = 2; s < 8; s++) model_step(8'h9A, 1'b0);
    check("R7 result unaffected", final_code_o, 8'h9A);
    check("R7 done after full search", done_o, 1);

    // R8: idle step strobe has no effect
    @(negedge clk);
    prev = trial_code_o;
    sign_async_i = 1'b1;
    repeat (3) @(negedge clk);
    step_once(1'b0);
    check("R8 trial unchanged", trial_code_o, prev);
    check("R8 final unchanged", final_code_o, 8'h9A);
    check("R8 no done", done_o, 0);
    check("R8 still idle", busy_o, 0);

    // R4: synchronizer latency
    sign_async_i = 1'b1;
    repeat (3) @(negedge clk);
    begin_search();
    repeat (3) @(negedge clk);
    sign_async_i = 1'b0;          // changes at the step edge itself
    step_once(1'b0);
    check("R4 old sign used at step edge", trial_code_o, 8'hC0);
    repeat (3) @(negedge clk);
    step_once(1'b0);
    check("R4 settled sign used", trial_code_o, 8'hA0);
    sign_async_i = 1'b1;          // one cycle before the step
    @(negedge clk);
    step_once(1'b0);
    check("R4 one-cycle-late sign ignored", trial_code_o, 8'h90);
    sign_async_i = 1'b0;
    for (int s = 3; s < 8; s++) begin
      repeat (3) @(negedge clk);
      step_once(1'b0);
    end
    check("R4 result of sign sequence", final_code_o, 8'h80);

    // same-cycle: start with the last step, then start with done
    @(negedge clk);
    begin_search();
    for (int s = 0; s < 7; s++) model_step(8'h66, 1'b0);
    model_step(8'h66, 1'b1);
    check("R7 start with last step: done", done_o, 1);
    check("R7 start with last step: result", final_code_o, 8'h66);
    check("R7 start with last step: idle", busy_o, 0);
    begin_search();
    check("R2 start in done cycle: busy", busy_o, 1);
    check("R2 start in done cycle: trial", trial_code_o, 8'h80);
    check("R3 eight steps exactly: still busy", busy_o, 1);
    for (int s = 0; s < 8; s++) model_step(8'hFE, 1'b0);
    check("R3 eight steps: done", done_o, 1);
    check("R9 threshold FE", final_code_o, 8'hFE);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule